// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Two Static Memory Core

This block is a synthesizable behavioural model of a static memory with a read data port and a write data port that work on their own, each moving a burst of two words in every clock period. A read and a write may be issued together in one cycle. Commands, addresses and write data are taken on the rising edges of a complementary input clock pair (`k`, `k_n`). Read data is sent out on the rising edges of a second complementary pair (`c`, `c_n`), or of `k`/`k_n` when the output clocks are tied high.

A read command is given by `rd_sel_n` low at a `k` rise, with its address on the shared address bus. A write command is given by `wr_sel_n` low at a `k` rise. The first write word and its lane mask go in with that edge. The write address, the second word and its mask follow on the next `k_n` rise. The first word of a burst goes to the address that was captured. The second word goes to that address with its least significant bit forced to one. A free-running echo clock pair follows the output timing reference, so a receiver can use it to capture data. The array is small, and its depth and widths are parameters.

Top module: `qdr_b2_sram`

## Requirements
- R1: A read captured at a `k` rise (command cycle T) drives its first word on `rdata` from the output-reference falling-phase rise at T+1.5 cycles. It drives the second word from the output-reference rise at T+2 cycles.
- R2: Within a burst, word 0 uses the captured address A and word 1 uses A with bit 0 set. This applies to reads and to writes. When A is odd, both write words hit the same location, and word 1 wins on every lane it enables.
- R3: For a write, word 0 data and its mask are sampled at the `k` rise that carries `wr_sel_n` low. The address, word 1 data and its mask are sampled at the following `k_n` rise.
- R4: `lane_we_n` is active low, and bit b guards data bits [b*LW+LW-1 : b*LW], where LW = DW/NB. Each of the two write words has its own mask, and a lane that is not enabled keeps its old contents.
- R5: A read returns every write issued in the same or an earlier cycle, with masking applied. A read to the same location as a write in the same cycle returns the new data. A write issued in a later cycle is not seen.
- R6: `rvalid` is high exactly for the one cycle in which the two words of a read are on `rdata`. While `rvalid` is low, `rdata` is all zeros.
- R7: In a cycle with no read and no write, the address bus, data bus and lane enables change no stored word.
- R8: `echo` rises with the output-reference edge that launches word 1, and `echo_n` rises with the edge that launches word 0. Both toggle whether or not data is on the bus.
- R9: When `outclk_tied` is high, `k`/`k_n` act as the output reference and `c`/`c_n` are ignored. When it is low, `c`/`c_n` time the outputs, and while they are stopped no read data appears.
- R10: `rst_n` low clears `rvalid` and `rdata` at once. Its release takes effect on the second `k` rise after `rst_n` goes high. Array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k | input | 1 | Input clock, rising edge takes commands and write word 0 |
| k_n | input | 1 | Complement of `k`, rising edge takes write address and word 1 |
| c | input | 1 | Output clock, launches read word 1 |
| c_n | input | 1 | Complement output clock, launches read word 0 |
| rst_n | input | 1 | Asynchronous active-low reset |
| outclk_tied | input | 1 | High: use `k`/`k_n` as output reference |
| rd_sel_n | input | 1 | Active-low read select |
| wr_sel_n | input | 1 | Active-low write select |
| addr | input | AW | Shared read/write word address |
| lane_we_n | input | NB | Active-low per-lane write enables |
| wdata | input | DW | Write data bus |
| rdata | output | DW | Read data bus |
| rvalid | output | 1 | High while a read burst is on `rdata` |
| echo | output | 1 | Echo clock, follows word-1 reference |
| echo_n | output | 1 | Echo clock, follows word-0 reference |

## Verification
Word 0 of a read is due just after the `k_n` rise that comes 1.5 cycles after the command edge. Word 1 and the same `rvalid` are due just after the `k` rise two cycles after it. The bench drives each command half-cycle one time unit after the opposite edge, and it samples the outputs one unit after each rise. At each sampling point it compares against the model entry pushed two iterations earlier. Writes are applied to the model memory before a read in the same cycle is evaluated, and after any read in an earlier cycle, which follows the ordering of R5. The echo clocks are checked at both points, in every phase, including the phase with stopped output clocks.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int QDR_AW_DEF = 4;
  localparam int QDR_DW_DEF = 36;
  localparam int QDR_NB_DEF = 4;
  localparam int QDR_BURST  = 2;

  typedef enum logic {
    OREF_EXT   = 1'b0,
    OREF_INPUT = 1'b1
  } oref_e;
endpackage

// File: rtl/qdr_cmd_front.sv
module qdr_cmd_front #(
  parameter int AW = 4,
  parameter int DW = 36,
  parameter int NB = 4
) (
  input  logic          k,
  input  logic          rst_i,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] lane_we_n,
  output logic          rd_go,
  output logic [AW-1:0] rd_addr,
  output logic          wr_pend,
  output logic [DW-1:0] wd0,
  output logic [NB-1:0] wm0
);
  logic          rd_go_nx, wr_pend_nx;
  logic [AW-1:0] rd_addr_nx;
  logic [DW-1:0] wd0_nx;
  logic [NB-1:0] wm0_nx;
  logic          rd_en, wr_en;

  assign rd_en = ~rd_sel_n;
  assign wr_en = ~wr_sel_n;

  always_comb begin
    rd_go_nx   = rd_en;
    wr_pend_nx = wr_en;
    rd_addr_nx = rd_en ? addr : rd_addr;
    wd0_nx     = wr_en ? wdata : wd0;
    wm0_nx     = wr_en ? lane_we_n : wm0;
  end

  always_ff @(posedge k or negedge rst_i) begin
    if (!rst_i) begin
      rd_go   <= 1'b0;
      wr_pend <= 1'b0;
      rd_addr <= '0;
      wd0     <= '0;
      wm0     <= '1;
    end else begin
      rd_go   <= rd_go_nx;
      wr_pend <= wr_pend_nx;
      rd_addr <= rd_addr_nx;
      wd0     <= wd0_nx;
      wm0     <= wm0_nx;
    end
  end
endmodule

// File: rtl/qdr_lane_array.sv
module qdr_lane_array #(
  parameter int AW = 4,
  parameter int DW = 36,
  parameter int NB = 4
) (
  input  logic          k,
  input  logic          k_n,
  input  logic          rst_i,
  input  logic          wr_pend,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wd0,
  input  logic [NB-1:0] wm0,
  input  logic [DW-1:0] wd1,
  input  logic [NB-1:0] wm1,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ok,
  output logic [DW-1:0] rw0,
  output logic [DW-1:0] rw1
);
  localparam int LW    = DW / NB;
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] wa0, wa1, ra1;
  logic [DW-1:0] rd_w0, rd_w1;
  logic [DW-1:0] rw0_nx, rw1_nx;

  assign wa0 = wr_addr;
  assign wa1 = {wr_addr[AW-1:1], 1'b1};
  assign ra1 = {rd_addr[AW-1:1], 1'b1};

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [LW-1:0] store [DEPTH];

    always_ff @(posedge k_n) begin
      if (wr_pend) begin
        if (!wm0[b]) store[wa0] <= wd0[b*LW +: LW];
        if (!wm1[b]) store[wa1] <= wd1[b*LW +: LW];
      end
    end

    assign rd_w0[b*LW +: LW] = store[rd_addr];
    assign rd_w1[b*LW +: LW] = store[ra1];
  end

  always_comb begin
    rw0_nx = rd_go ? rd_w0 : rw0;
    rw1_nx = rd_go ? rd_w1 : rw1;
  end

  always_ff @(posedge k or negedge rst_i) begin
    if (!rst_i) begin
      rd_ok <= 1'b0;
      rw0   <= '0;
      rw1   <= '0;
    end else begin
      rd_ok <= rd_go;
      rw0   <= rw0_nx;
      rw1   <= rw1_nx;
    end
  end
endmodule

// File: rtl/qdr_ddr_out.sv
module qdr_ddr_out #(
  parameter int DW = 36
) (
  input  logic          oclk,
  input  logic          oclk_n,
  input  logic          rst_i,
  input  logic          rd_ok,
  input  logic [DW-1:0] rw0,
  input  logic [DW-1:0] rw1,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] qa, qa_nx, hold1, hold1_nx, qb;
  logic          vld_nx, ta, tb;

  always_comb begin
    vld_nx   = rd_ok;
    qa_nx    = rd_ok ? rw0 : '0;
    hold1_nx = rd_ok ? rw1 : '0;
  end

  always_ff @(posedge oclk_n or negedge rst_i) begin
    if (!rst_i) begin
      rvalid <= 1'b0;
      qa     <= '0;
      hold1  <= '0;
      ta     <= 1'b0;
    end else begin
      rvalid <= vld_nx;
      qa     <= qa_nx;
      hold1  <= hold1_nx;
      ta     <= ~ta;
    end
  end

  always_ff @(posedge oclk or negedge rst_i) begin
    if (!rst_i) begin
      qb <= '0;
      tb <= 1'b0;
    end else begin
      qb <= hold1;
      tb <= ~tb;
    end
  end

  assign rdata = (ta ^ tb) ? qa : qb;
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
  import qdr_pkg::*;
#(
  parameter int AW = QDR_AW_DEF,
  parameter int DW = QDR_DW_DEF,
  parameter int NB = QDR_NB_DEF
) (
  input  logic          k,
  input  logic          k_n,
  input  logic          c,
  input  logic          c_n,
  input  logic          rst_n,
  input  logic          outclk_tied,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] lane_we_n,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          echo,
  output logic          echo_n
);
  logic [1:0]    rst_sync;
  logic          rst_i;
  oref_e         oref;
  logic          oclk, oclk_n;
  logic          rd_go, wr_pend, rd_ok;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] wd0, rw0, rw1;
  logic [NB-1:0] wm0;

  always_ff @(posedge k or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_n & rst_sync[1];

  assign oref   = outclk_tied ? OREF_INPUT : OREF_EXT;
  assign oclk   = (oref == OREF_INPUT) ? k   : c;
  assign oclk_n = (oref == OREF_INPUT) ? k_n : c_n;
  assign echo   = oclk;
  assign echo_n = oclk_n;

  qdr_cmd_front #(.AW(AW), .DW(DW), .NB(NB)) u_front (
    .k(k), .rst_i(rst_i), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .wdata(wdata), .lane_we_n(lane_we_n),
    .rd_go(rd_go), .rd_addr(rd_addr), .wr_pend(wr_pend), .wd0(wd0), .wm0(wm0)
  );

  qdr_lane_array #(.AW(AW), .DW(DW), .NB(NB)) u_array (
    .k(k), .k_n(k_n), .rst_i(rst_i), .wr_pend(wr_pend), .wr_addr(addr),
    .wd0(wd0), .wm0(wm0), .wd1(wdata), .wm1(lane_we_n),
    .rd_go(rd_go), .rd_addr(rd_addr), .rd_ok(rd_ok), .rw0(rw0), .rw1(rw1)
  );

  qdr_ddr_out #(.DW(DW)) u_out (
    .oclk(oclk), .oclk_n(oclk_n), .rst_i(rst_i), .rd_ok(rd_ok),
    .rw0(rw0), .rw1(rw1), .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: rtl/qdr_b2_sram_chk.sv
module qdr_b2_sram_chk #(
  parameter int DW = 36
) (
  input logic          k,
  input logic          rst_n,
  input logic          outclk_tied,
  input logic          rd_sel_n,
  input logic          rvalid,
  input logic [DW-1:0] rdata
);
  logic [1:0] cyc;
  logic       low_seen;

  always @(posedge k or negedge rst_n) begin
    if (!rst_n)         cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  always @(posedge k) begin
    low_seen <= !rst_n;
    if (low_seen === 1'b1 && !rst_n)
      p_reset_quiet_r10: assert (!rvalid && rdata == '0);
  end

  p_valid_has_read_r6: assert property (@(posedge k) disable iff (!rst_n)
    (cyc == 2'd3 && rvalid) |-> !$past(rd_sel_n, 2));

  p_read_latency_r1: assert property (@(posedge k) disable iff (!rst_n)
    (cyc == 2'd3 && outclk_tied && !$past(rd_sel_n, 2)) |-> rvalid);

  p_idle_bus_zero_r6: assert property (@(negedge k) disable iff (!rst_n)
    (cyc == 2'd3 && !rvalid) |-> (rdata == '0));

  p_valid_pairs_r6: assert property (@(posedge k) disable iff (!rst_n)
    (cyc == 2'd3 && rvalid && $past(rd_sel_n, 3)) |-> !$past(rd_sel_n, 2));
endmodule

bind qdr_b2_sram qdr_b2_sram_chk #(.DW(DW)) u_chk (
  .k(k), .rst_n(rst_n), .outclk_tied(outclk_tied), .rd_sel_n(rd_sel_n),
  .rvalid(rvalid), .rdata(rdata)
);

// File: tb/qdr_b2_sram_test.sv
module qdr_b2_sram_test;
  localparam int CLK_PER = 10;
  localparam int AW = 4;
  localparam int DW = 36;
  localparam int NB = 4;
  localparam int LW = DW / NB;
  localparam int DEPTH = 1 << AW;

  logic k = 1'b0, rst_n = 1'b1, tie = 1'b0, freeze = 1'b0;
  logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] lane_we_n = '1;
  logic [DW-1:0] wdata = '0;
  wire  k_n = ~k;
  wire  c   = tie ? 1'b1 : (freeze ? 1'b0 : k);
  wire  c_n = tie ? 1'b1 : (freeze ? 1'b0 : k_n);
  logic [DW-1:0] rdata;
  logic rvalid, echo, echo_n;

  int vectors = 0, fails = 0;
  logic [DW-1:0] mm [DEPTH];
  logic          ev [$];
  logic [DW-1:0] e0 [$];
  logic [DW-1:0] e1 [$];
  string         et [$];

  always #(CLK_PER/2) k = ~k;

  qdr_b2_sram #(.AW(AW), .DW(DW), .NB(NB)) uut (
    .k(k), .k_n(k_n), .c(c), .c_n(c_n), .rst_n(rst_n), .outclk_tied(tie),
    .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .addr(addr),
    .lane_we_n(lane_we_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .echo(echo), .echo_n(echo_n)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd();
    logic [63:0] t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  task automatic model_write(input logic [AW-1:0] wa, input logic [DW-1:0] d0,
                             input logic [NB-1:0] m0, input logic [DW-1:0] d1,
                             input logic [NB-1:0] m1);
    logic [AW-1:0] wb = wa | 1;
    for (int b = 0; b < NB; b++) if (!m0[b]) mm[wa][b*LW +: LW] = d0[b*LW +: LW];
    for (int b = 0; b < NB; b++) if (!m1[b]) mm[wb][b*LW +: LW] = d1[b*LW +: LW];
  endtask

  // one command cycle; outputs checked against the entry from two cycles back
  task automatic cyc(input string tag, input logic rd, input logic wr,
                     input logic [AW-1:0] ra, input logic [AW-1:0] wa,
                     input logic [DW-1:0] d0, input logic [NB-1:0] m0,
                     input logic [DW-1:0] d1, input logic [NB-1:0] m1);
    logic [AW-1:0] rb = ra | 1;
    @(posedge k_n); #1;
    chk(et[0], "rvalid(w0 phase)", 64'(rvalid), 64'(ev[0]));
    chk(et[0], "rdata word0", 64'(rdata), 64'(ev[0] ? e0[0] : '0));
    chk("R8", "echo pair after k_n rise", 64'({echo, echo_n}), 64'(2'b01));
    rd_sel_n = ~rd; wr_sel_n = ~wr; addr = ra; wdata = d0; lane_we_n = m0;
    @(posedge k); #1;
    chk(et[0], "rvalid(w1 phase)", 64'(rvalid), 64'(ev[0]));
    chk(et[0], "rdata word1", 64'(rdata), 64'(ev[0] ? e1[0] : '0));
    chk("R8", "echo pair after k rise", 64'({echo, echo_n}), 64'(2'b10));
    void'(ev.pop_front()); void'(e0.pop_front()); void'(e1.pop_front());
    void'(et.pop_front());
    addr = wa; wdata = d1; lane_we_n = m1;
    if (wr) model_write(wa, d0, m0, d1, m1);
    ev.push_back(rd); e0.push_back(mm[ra]); e1.push_back(mm[rb]); et.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      cyc("R7", 1'b0, 1'b0, AW'($urandom()), AW'($urandom()), rnd(), NB'($urandom()),
          rnd(), NB'($urandom()));
  endtask

  task automatic do_reset();
    @(posedge k); #1;
    rst_n = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    repeat (2) @(posedge k);
    #1;
    chk("R10", "rvalid in reset", 64'(rvalid), 64'(0));
    chk("R10", "rdata in reset", 64'(rdata), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(posedge k);
    #1;
    ev.delete(); e0.delete(); e1.delete(); et.delete();
    repeat (2) begin
      ev.push_back(1'b0); e0.push_back('0); e1.push_back('0); et.push_back("R6");
    end
  endtask

  initial begin
    #(CLK_PER * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] x, y;
    #1 rst_n = 1'b0;
    do_reset();
    // fill array, even-address bursts with all lanes
    for (int a = 0; a < DEPTH; a += 2)
      cyc("R3", 1'b0, 1'b1, '0, AW'(a), rnd(), '0, rnd(), '0);
    for (int a = 0; a < DEPTH; a++)
      cyc("R2", 1'b1, 1'b0, AW'(a), '0, '0, '1, '0, '1);
    idle(2);
    // per-word lane masks
    cyc("R4", 1'b0, 1'b1, '0, 4'd6, rnd(), 4'b0101, rnd(), 4'b1010);
    cyc("R4", 1'b1, 1'b0, 4'd6, '0, '0, '1, '0, '1);
    cyc("R4", 1'b0, 1'b1, '0, 4'd8, rnd(), 4'b1111, rnd(), 4'b0000);
    cyc("R4", 1'b1, 1'b0, 4'd8, '0, '0, '1, '0, '1);
    // odd write address: both words one location, word1 wins
    cyc("R2", 1'b0, 1'b1, '0, 4'd3, rnd(), 4'b0011, rnd(), 4'b0110);
    cyc("R2", 1'b1, 1'b0, 4'd2, '0, '0, '1, '0, '1);
    // same-cycle read and write to one location
    x = rnd(); y = rnd();
    cyc("R5", 1'b1, 1'b1, 4'd10, 4'd10, x, 4'b0100, y, 4'b0000);
    // read before a later write to same place
    cyc("R5", 1'b1, 1'b0, 4'd12, '0, '0, '1, '0, '1);
    cyc("R5", 1'b0, 1'b1, '0, 4'd12, rnd(), '0, rnd(), '0);
    cyc("R5", 1'b1, 1'b0, 4'd12, '0, '0, '1, '0, '1);
    idle(6);
    for (int a = 0; a < DEPTH; a += 2)
      cyc("R7", 1'b1, 1'b0, AW'(a), '0, '0, '1, '0, '1);
    // mixed concurrent traffic, external output clocks
    for (int i = 0; i < 300; i++)
      cyc("R1", 1'($urandom()), 1'($urandom()), AW'($urandom()), AW'($urandom()),
          rnd(), NB'($urandom()), rnd(), NB'($urandom()));
    idle(2);
    // input clocks as output reference
    tie = 1'b1;
    do_reset();
    for (int i = 0; i < 300; i++)
      cyc("R9", 1'($urandom()), 1'($urandom()), AW'($urandom()), AW'($urandom()),
          rnd(), NB'($urandom()), rnd(), NB'($urandom()));
    idle(2);
    // stopped external output clocks: no data, echoes still
    tie = 1'b0;
    freeze = 1'b1;
    do_reset();
    @(posedge k_n); #1;
    rd_sel_n = 1'b0; addr = 4'd4;
    @(posedge k); #1;
    rd_sel_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge k_n); #1;
      chk("R9", "rvalid with stopped c", 64'(rvalid), 64'(0));
      chk("R9", "rdata with stopped c", 64'(rdata), 64'(0));
      chk("R8", "echo follows stopped c", 64'({echo, echo_n}), 64'(2'b00));
    end
    @(posedge k); #1;
    rst_n = 1'b0;
    freeze = 1'b0;
    do_reset();
    cyc("R1", 1'b1, 1'b0, 4'd4, '0, '0, '1, '0, '1);
    idle(3);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule